// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flag Word

This block performs the two-operand integer arithmetic and bitwise work of a small processor datapath and keeps the status flag word that goes with it. An operation code picks add, add-with-carry, subtract, subtract-with-borrow, AND, OR or XOR. A size input picks whether the operation works on the low byte or on the full 16-bit word. When the execute strobe is high on a clock edge, the block registers the result. In the same edge it registers the carry, parity, auxiliary-carry, zero, sign and overflow flags that the result produces.

The same flag word holds three control bits: direction, interrupt enable and trap. Arithmetic and logic work never changes them. Each one moves only on its own set or clear pulse. A whole-word load path writes every defined flag bit at once, so saved flags can be restored. The flag word is always visible on an output port. The add-with-carry and subtract-with-borrow operations use the carry flag currently held in the register as their carry input.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag word holds carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Every other bit always reads 0, including after a whole-word load of all ones.
- R2: Each operation code has one meaning: 0 is add, 1 is add with carry, 2 is subtract (a minus b), 3 is subtract with borrow (a minus b minus carry), 4 is AND, 5 is OR and 6 is XOR. Codes 1 and 3 take the registered carry flag as their input. The result is on result_o in the cycle after the clock edge on which exec_i is high.
- R3: For arithmetic codes, carry is set when the sum carries out of the top bit of the active width, or when the subtraction borrows into that bit.
- R4: For arithmetic codes, auxiliary carry is set when there is a carry out of bit 3 into bit 4, or a borrow from bit 4 into bit 3. Logic codes clear it.
- R5: Parity is set when the low byte of the result holds an even number of 1 bits. This holds in both sizes.
- R6: Zero is set when the result is all zeros over the active width. Sign copies the top bit of the active width (bit 7 in byte mode, bit 15 in word mode).
- R7: For arithmetic codes, overflow is set when the true signed result does not fit the active width. Logic codes clear both overflow and carry.
- R8: With byte_i high, only the low bytes of the operands take part, and result_o[15:8] reads 0.
- R9: The trap, interrupt-enable and direction bits change only on their own set or clear inputs. Clear wins when both are high in one cycle. An executed operation leaves these bits unchanged.
- R10: A high fw_load_i loads all nine defined flags from fw_data_i at the next edge. In that cycle it overrides any execute and any set or clear input: those are dropped and result_o keeps its value.
- R11: With exec_i low, or with operation code 7, result_o and the six status flags keep their values.
- R12: After reset, result_o and the flag word are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; registers result and status flags |
| op_i | input | 3 | Operation code (see R2) |
| byte_i | input | 1 | 1 selects byte size, 0 selects word size |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| tr_set_i | input | 1 | Set the trap bit |
| tr_clr_i | input | 1 | Clear the trap bit |
| ie_set_i | input | 1 | Set the interrupt-enable bit |
| ie_clr_i | input | 1 | Clear the interrupt-enable bit |
| dir_set_i | input | 1 | Set the direction bit |
| dir_clr_i | input | 1 | Clear the direction bit |
| fw_load_i | input | 1 | Load the whole flag word |
| fw_data_i | input | 16 | Value for the whole-word load |
| result_o | output | 16 | Registered result |
| flags_o | output | 16 | Registered flag word |

## Verification
Every result of this block sits behind exactly one register stage. The result, the six status flags, the control bits and a whole-word load all appear one clock edge after the inputs that caused them. The bench drives each stimulus on a falling edge and waits for the next rising edge. It samples one time unit later and compares against a reference model. That model advances its own result and flag state by one step per cycle. Checks that a value holds, such as idle cycles, code 7 or a load that overrides an execute, compare against the model's unchanged copy at that same sample point.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int NIB_W  = 4;
    localparam int FLAG_W = 16;
    localparam int CTL_N  = 3;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IE_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;

    localparam logic [FLAG_W-1:0] USED_MASK =
        (FLAG_W'(1) << CF_BIT) | (FLAG_W'(1) << PF_BIT) | (FLAG_W'(1) << AF_BIT) |
        (FLAG_W'(1) << ZF_BIT) | (FLAG_W'(1) << SF_BIT) | (FLAG_W'(1) << TF_BIT) |
        (FLAG_W'(1) << IE_BIT) | (FLAG_W'(1) << DF_BIT) | (FLAG_W'(1) << OF_BIT);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_NOP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cf;
        logic              pf;
        logic              af;
        logic              zf;
        logic              sf;
        logic              tf;
        logic              ief;
        logic              df;
        logic              of;
    } alu_state_t;

endpackage

// File: rtl/alu_add_core.sv
`timescale 1ns/1ps
module alu_add_core #(
    parameter int W     = 16,
    parameter int BW    = 8,
    parameter int NW    = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         c_half_o,
    output logic         c_out_o,
    output logic         v_o
);
    logic [W:0]  full_s;
    logic [BW:0] byte_s;
    logic [NW:0] nib_s;
    logic        top_a;
    logic        top_b;
    logic        top_s;

    always_comb begin
        full_s   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        byte_s   = {1'b0, a_i[BW-1:0]} + {1'b0, b_i[BW-1:0]} + {{BW{1'b0}}, cin_i};
        nib_s    = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
        sum_o    = full_s[W-1:0];
        c_half_o = nib_s[NW];
        c_out_o  = byte_i ? byte_s[BW] : full_s[W];
        top_a    = byte_i ? a_i[BW-1]    : a_i[W-1];
        top_b    = byte_i ? b_i[BW-1]    : b_i[W-1];
        top_s    = byte_i ? full_s[BW-1] : full_s[W-1];
        v_o      = (top_a == top_b) && (top_s != top_a);
    end
endmodule

// File: rtl/alu_status_eval.sv
`timescale 1ns/1ps
module alu_status_eval #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic [W-1:0] res_i,
    input  logic         byte_i,
    output logic         zf_o,
    output logic         sf_o,
    output logic         pf_o
);
    logic [BW:0] par_chain;

    assign par_chain[0] = 1'b1;
    for (genvar g = 0; g < BW; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ res_i[g];
    end

    always_comb begin
        pf_o = par_chain[BW];
        zf_o = byte_i ? ~|res_i[BW-1:0] : ~|res_i;
        sf_o = byte_i ? res_i[BW-1] : res_i[W-1];
    end
endmodule

// File: rtl/alu_ctl_bit.sv
`timescale 1ns/1ps
module alu_ctl_bit (
    input  logic cur_i,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_o
);
    always_comb begin
        if (clr_i)      nxt_o = 1'b0;
        else if (set_i) nxt_o = 1'b1;
        else            nxt_o = cur_i;
    end
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
    import alu_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [2:0]        op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              tr_set_i,
    input  logic              tr_clr_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              dir_set_i,
    input  logic              dir_clr_i,
    input  logic              fw_load_i,
    input  logic [FLAG_W-1:0] fw_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    alu_state_t        st_d, st_q;
    alu_op_e           op;
    logic              is_sub;
    logic              is_logic;
    logic [DATA_W-1:0] a_m, b_m, b_eff, logic_res, sum, res_sel;
    logic              cin, c_half, c_out, v_flag;
    logic              zf_n, sf_n, pf_n;
    logic [CTL_N-1:0]  ctl_cur, ctl_set, ctl_clr, ctl_nxt;

    always_comb begin
        op       = alu_op_e'(op_i);
        is_sub   = (op == OP_SUB) || (op == OP_SBB);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        a_m      = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, a_i[BYTE_W-1:0]} : a_i;
        b_m      = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, b_i[BYTE_W-1:0]} : b_i;
        b_eff    = is_sub ? ~b_m : b_m;
        case (op)
            OP_ADC:  cin = st_q.cf;
            OP_SUB:  cin = 1'b1;
            OP_SBB:  cin = ~st_q.cf;
            default: cin = 1'b0;
        endcase
        case (op)
            OP_AND:  logic_res = a_m & b_m;
            OP_OR:   logic_res = a_m | b_m;
            default: logic_res = a_m ^ b_m;
        endcase
        res_sel = is_logic ? logic_res : sum;
        if (byte_i) res_sel[DATA_W-1:BYTE_W] = '0;
    end

    alu_add_core #(.W(DATA_W), .BW(BYTE_W), .NW(NIB_W)) u_add (
        .a_i      (a_m),
        .b_i      (b_eff),
        .cin_i    (cin),
        .byte_i   (byte_i),
        .sum_o    (sum),
        .c_half_o (c_half),
        .c_out_o  (c_out),
        .v_o      (v_flag)
    );

    alu_status_eval #(.W(DATA_W), .BW(BYTE_W)) u_stat (
        .res_i  (res_sel),
        .byte_i (byte_i),
        .zf_o   (zf_n),
        .sf_o   (sf_n),
        .pf_o   (pf_n)
    );

    assign ctl_cur = {st_q.df, st_q.ief, st_q.tf};
    assign ctl_set = {dir_set_i, ie_set_i, tr_set_i};
    assign ctl_clr = {dir_clr_i, ie_clr_i, tr_clr_i};

    for (genvar c = 0; c < CTL_N; c++) begin : g_ctl
        alu_ctl_bit u_bit (
            .cur_i (ctl_cur[c]),
            .set_i (ctl_set[c]),
            .clr_i (ctl_clr[c]),
            .nxt_o (ctl_nxt[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (fw_load_i) begin
            st_d.cf  = fw_data_i[CF_BIT];
            st_d.pf  = fw_data_i[PF_BIT];
            st_d.af  = fw_data_i[AF_BIT];
            st_d.zf  = fw_data_i[ZF_BIT];
            st_d.sf  = fw_data_i[SF_BIT];
            st_d.tf  = fw_data_i[TF_BIT];
            st_d.ief = fw_data_i[IE_BIT];
            st_d.df  = fw_data_i[DF_BIT];
            st_d.of  = fw_data_i[OF_BIT];
        end else begin
            if (exec_i && (op != OP_NOP)) begin
                st_d.res = res_sel;
                st_d.zf  = zf_n;
                st_d.sf  = sf_n;
                st_d.pf  = pf_n;
                if (is_logic) begin
                    st_d.cf = 1'b0;
                    st_d.af = 1'b0;
                    st_d.of = 1'b0;
                end else begin
                    st_d.cf = is_sub ? ~c_out  : c_out;
                    st_d.af = is_sub ? ~c_half : c_half;
                    st_d.of = v_flag;
                end
            end
            st_d.tf  = ctl_nxt[0];
            st_d.ief = ctl_nxt[1];
            st_d.df  = ctl_nxt[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        result_o         = st_q.res;
        flags_o          = '0;
        flags_o[CF_BIT]  = st_q.cf;
        flags_o[PF_BIT]  = st_q.pf;
        flags_o[AF_BIT]  = st_q.af;
        flags_o[ZF_BIT]  = st_q.zf;
        flags_o[SF_BIT]  = st_q.sf;
        flags_o[TF_BIT]  = st_q.tf;
        flags_o[IE_BIT]  = st_q.ief;
        flags_o[DF_BIT]  = st_q.df;
        flags_o[OF_BIT]  = st_q.of;
    end
endmodule

// File: rtl/alu_flag_unit_chk.sv
`timescale 1ns/1ps
module alu_flag_unit_chk
    import alu_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [2:0]        op_i,
    input logic              byte_i,
    input logic              tr_set_i,
    input logic              tr_clr_i,
    input logic              ie_set_i,
    input logic              ie_clr_i,
    input logic              dir_set_i,
    input logic              dir_clr_i,
    input logic              fw_load_i,
    input logic [FLAG_W-1:0] fw_data_i,
    input logic [DATA_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] STAT_MASK =
        USED_MASK & ~((FLAG_W'(1) << TF_BIT) | (FLAG_W'(1) << IE_BIT) | (FLAG_W'(1) << DF_BIT));

    logic any_ctl;
    logic did_exec;
    logic did_logic;
    assign any_ctl   = tr_set_i | tr_clr_i | ie_set_i | ie_clr_i | dir_set_i | dir_clr_i;
    assign did_exec  = !fw_load_i && exec_i && (op_i != 3'd7);
    assign did_logic = did_exec && (op_i >= 3'd4);

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_load_i && !any_ctl) |=> $stable(flags_o[DF_BIT:TF_BIT]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_load_i && !did_exec) |=> ($stable(result_o) && $stable(flags_o & STAT_MASK)));

    // R7
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        did_logic |=> (!flags_o[CF_BIT] && !flags_o[OF_BIT] && !flags_o[AF_BIT]));

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_load_i |=> (flags_o == ($past(fw_data_i) & USED_MASK)));

    // R10
    load_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_load_i |=> $stable(result_o));

    // R6
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        did_exec |=> (flags_o[ZF_BIT] == ($past(byte_i) ? (result_o[BYTE_W-1:0] == '0) : (result_o == '0))));

    // R8
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (did_exec && byte_i) |=> (result_o[DATA_W-1:BYTE_W] == '0));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .op_i      (op_i),
    .byte_i    (byte_i),
    .tr_set_i  (tr_set_i),
    .tr_clr_i  (tr_clr_i),
    .ie_set_i  (ie_set_i),
    .ie_clr_i  (ie_clr_i),
    .dir_set_i (dir_set_i),
    .dir_clr_i (dir_clr_i),
    .fw_load_i (fw_load_i),
    .fw_data_i (fw_data_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] a_i = '0, b_i = '0;
    logic        tr_set_i = 0, tr_clr_i = 0, ie_set_i = 0, ie_clr_i = 0, dir_set_i = 0, dir_clr_i = 0;
    logic        fw_load_i = 1'b0;
    logic [15:0] fw_data_i = '0;
    logic [15:0] result_o, flags_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_res = '0;
    logic [15:0] exp_flg = '0;

    always #5 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .byte_i(byte_i),
        .a_i(a_i), .b_i(b_i),
        .tr_set_i(tr_set_i), .tr_clr_i(tr_clr_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .dir_set_i(dir_set_i), .dir_clr_i(dir_clr_i),
        .fw_load_i(fw_load_i), .fw_data_i(fw_data_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sc = {dir_set, dir_clr, ie_set, ie_clr, tr_set, tr_clr}
    function automatic logic [31:0] model_next(
        input logic [15:0] r, input logic [15:0] f, input logic ex, input logic [2:0] op,
        input logic bm, input logic [15:0] a, input logic [15:0] b, input logic [5:0] sc,
        input logic ld, input logic [15:0] ldd);
        int w, m, ua, ub, sa, sb, c, s, ss, lo, hi;
        logic [15:0] nr, nf;
        if (ld) return {r, ldd & 16'h0FD5};
        nr = r;
        nf = f;
        if (ex && op != 3'd7) begin
            w  = bm ? 8 : 16;
            m  = (1 << w) - 1;
            ua = int'(a) & m;
            ub = int'(b) & m;
            sa = (ua > (m >> 1)) ? ua - (m + 1) : ua;
            sb = (ub > (m >> 1)) ? ub - (m + 1) : ub;
            c  = (op == 3'd1 || op == 3'd3) ? int'(f[0]) : 0;
            lo = -((m + 1) / 2);
            hi = (m - 1) / 2;
            s  = 0;
            ss = 0;
            case (op)
                3'd0, 3'd1: begin
                    s = ua + ub + c; ss = sa + sb + c;
                    nf[0] = (s > m);
                    nf[4] = (((ua & 15) + (ub & 15) + c) > 15);
                end
                3'd2, 3'd3: begin
                    s = ua - ub - c; ss = sa - sb - c;
                    nf[0] = (s < 0);
                    nf[4] = (((ua & 15) - (ub & 15) - c) < 0);
                end
                3'd4: s = ua & ub;
                3'd5: s = ua | ub;
                default: s = ua ^ ub;
            endcase
            if (op >= 3'd4) begin
                nf[0] = 1'b0; nf[4] = 1'b0; nf[11] = 1'b0;
            end else begin
                nf[11] = (ss < lo) || (ss > hi);
            end
            nr    = 16'(s & m);
            nf[6] = (nr == 16'h0);
            nf[7] = bm ? nr[7] : nr[15];
            nf[2] = ($countones(nr[7:0]) % 2) == 0;
        end
        nf[10] = sc[4] ? 1'b0 : (sc[5] ? 1'b1 : f[10]);
        nf[9]  = sc[2] ? 1'b0 : (sc[3] ? 1'b1 : f[9]);
        nf[8]  = sc[0] ? 1'b0 : (sc[1] ? 1'b1 : f[8]);
        return {nr, nf};
    endfunction

    task automatic run(input logic ex, input logic [2:0] op, input logic bm,
                       input logic [15:0] a, input logic [15:0] b, input logic [5:0] sc,
                       input logic ld, input logic [15:0] ldd, input string tag);
        logic [31:0] nx;
        nx = model_next(exp_res, exp_flg, ex, op, bm, a, b, sc, ld, ldd);
        exec_i = ex; op_i = op; byte_i = bm; a_i = a; b_i = b;
        {dir_set_i, dir_clr_i, ie_set_i, ie_clr_i, tr_set_i, tr_clr_i} = sc;
        fw_load_i = ld; fw_data_i = ldd;
        @(posedge clk);
        #1;
        exp_res = nx[31:16];
        exp_flg = nx[15:0];
        check({tag, " result"}, result_o, exp_res);
        check({tag, " flags"}, flags_o, exp_flg);
        @(negedge clk);
        exec_i = 0; fw_load_i = 0;
        {dir_set_i, dir_clr_i, ie_set_i, ie_clr_i, tr_set_i, tr_clr_i} = '0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12 reset result", result_o, 16'h0000);
        check("R12 reset flags", flags_o, 16'h0000);

        // R7 signed overflow, R6 sign
        run(1, 3'd0, 0, 16'h7FFF, 16'h0001, 6'b0, 0, 16'h0, "R7 R6 add overflow");
        check("R7 overflow bit", flags_o & 16'h0800, 16'h0800);
        // R3 carry out and R6 zero
        run(1, 3'd0, 0, 16'hFFFF, 16'h0001, 6'b0, 0, 16'h0, "R3 R6 add wrap");
        check("R3 carry and zero", flags_o & 16'h0041, 16'h0041);
        // R2 add with carry uses held carry
        run(1, 3'd1, 0, 16'h1000, 16'h0234, 6'b0, 0, 16'h0, "R2 adc");
        check("R2 adc sum", result_o, 16'h1235);
        // R4 byte nibble carry, R8 upper byte ignored
        run(1, 3'd0, 1, 16'h120F, 16'h3401, 6'b0, 0, 16'h0, "R4 R8 byte add");
        check("R8 byte result", result_o, 16'h0010);
        // R3 borrow
        run(1, 3'd2, 0, 16'h0000, 16'h0001, 6'b0, 0, 16'h0, "R3 R4 sub borrow");
        check("R3 borrow flag", flags_o & 16'h0001, 16'h0001);
        run(1, 3'd3, 0, 16'h0005, 16'h0003, 6'b0, 0, 16'h0, "R2 sbb");
        check("R2 sbb difference", result_o, 16'h0001);
        // R7 byte overflow on subtract
        run(1, 3'd2, 1, 16'h0080, 16'h0001, 6'b0, 0, 16'h0, "R7 R8 byte sub overflow");
        // R5 parity even / odd
        run(1, 3'd6, 0, 16'hFF00, 16'h0003, 6'b0, 0, 16'h0, "R5 parity even");
        check("R5 pf set", flags_o & 16'h0004, 16'h0004);
        run(1, 3'd5, 0, 16'h0100, 16'h0007, 6'b0, 0, 16'h0, "R5 parity odd");
        check("R5 pf clear", flags_o & 16'h0004, 16'h0000);
        // R7 logic clears carry/overflow after a carry-setting add
        run(1, 3'd0, 0, 16'h8000, 16'h8000, 6'b0, 0, 16'h0, "R3 R7 carry+overflow");
        run(1, 3'd4, 0, 16'hF0F0, 16'h0FF0, 6'b0, 0, 16'h0, "R7 R4 and clears");
        check("R7 cf of af cleared", flags_o & 16'h0811, 16'h0000);
        // R9 control set, hold under execute, clear wins
        run(0, 3'd0, 0, 16'h0, 16'h0, 6'b101010, 0, 16'h0, "R9 set all");
        check("R9 control set", flags_o & 16'h0700, 16'h0700);
        run(1, 3'd2, 0, 16'h1234, 16'h1234, 6'b0, 0, 16'h0, "R9 exec keeps ctl");
        check("R9 ctl unchanged", flags_o & 16'h0700, 16'h0700);
        run(0, 3'd0, 0, 16'h0, 16'h0, 6'b111111, 0, 16'h0, "R9 clear wins");
        check("R9 ctl cleared", flags_o & 16'h0700, 16'h0000);
        // R10 and R1 load with all ones, load beats execute and set
        run(1, 3'd0, 0, 16'h0001, 16'h0001, 6'b101010, 1, 16'hFFFF, "R10 R1 load");
        check("R1 unused bits zero", flags_o, 16'h0FD5);
        run(0, 3'd0, 0, 16'h0, 16'h0, 6'b0, 1, 16'h0000, "R10 load zeros");
        // R11 idle and opcode 7 hold
        run(1, 3'd0, 0, 16'h00F0, 16'h000F, 6'b0, 0, 16'h0, "R2 add");
        run(0, 3'd0, 0, 16'hFFFF, 16'hFFFF, 6'b0, 0, 16'h0, "R11 idle hold");
        run(1, 3'd7, 0, 16'hFFFF, 16'h0001, 6'b0, 0, 16'h0, "R11 op7 hold");
        check("R11 result kept", result_o, 16'h00FF);

        for (int i = 0; i < 800; i++) begin
            logic       ex, bm, ld;
            logic [2:0] op;
            logic [5:0] sc;
            ex = ($urandom % 8) != 0;
            op = 3'($urandom % 8);
            bm = 1'($urandom % 2);
            sc = (($urandom % 4) == 0) ? 6'($urandom) : 6'b0;
            ld = ($urandom % 32) == 0;
            run(ex, op, bm, 16'($urandom), 16'($urandom), sc, ld, 16'($urandom),
                "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule